// File: doc/BRIEF.md
# Dual-Port Word Memory with Same-Address Arbitration

This block is a true dual-port memory. Two independent ports, called left and right, share one storage array. Both ports are clocked by the same clock, and every write is split into 8-bit byte lanes. Each port has the following controls:

- an address
- write data
- a per-lane write mask
- a select
- a side-channel select that takes the port off the array
- an output enable
- registered read data

The block watches both ports at all times. When both are on the array at the same word, one port is granted and the other is told it is blocked. The port that came to the word first is granted. A blocked port may still read, but its writes are held back. A held write is committed on the first clock edge after the block is lifted, provided the write request is still present.

A strap input selects master or slave behaviour so that several copies can be placed side by side to build a wider word.

- In master mode, the copy's own arbitration result drives its blocked outputs.
- In slave mode, the blocked outputs stay low. External blocked inputs, normally driven by a master's outputs, gate only that copy's writes.

The word count is set by the address-width parameter. The full-size configuration uses a 14-bit address, giving 16K words of 32 bits. The default parameters build a smaller array of the same behaviour.

Top module: `dpram_arb`

## Requirements
- R1: A write commits only the byte lanes whose mask bits are set. Mask bit i controls data bits [8i+7:8i]. The other lanes of the word keep their old contents.
- R2: A port uses the array only when its select is 1 and its side-channel select is 0. Otherwise its writes change nothing and its read data is 0 after the next edge.
- R3: A read is a cycle with the port active, output enable 1 and a mask of zero. The word appears on read data one clock after the request. After any cycle that is not a read, read data is 0.
- R4: When the two ports are at different addresses, neither blocked output is ever raised. Both ports may write in the same cycle.
- R5: When both ports become active on one word, the port that was already active at that address in the previous cycle wins. The other port's blocked output is 1 for as long as the overlap lasts. The winner keeps the grant while it stays on the word.
- R6: When both ports reach the same word in the same cycle, the left port wins and only the right blocked output goes to 1. The two blocked outputs are never both 1.
- R7: A blocked port's write does not change the array. If the write is still requested in the first cycle without the block, it commits at that edge.
- R8: The blocked output falls in the same cycle that the winning port deselects or moves to another address.
- R9: A read that collides with a write from the other port to the same word returns the data held before that write.
- R10: With the strap at 0 (slave), both blocked outputs stay 0. Each port's external blocked input, when 1, suppresses that port's writes only. Reads are unaffected.
- R11: While reset is low, both read data outputs are 0 after each edge and both blocked outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Synchronous active-low reset |
| is_master | input | 1 | 1: drive blocked outputs from own arbitration; 0: gate writes from blocked inputs |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | DATA_W | Left write data |
| l_byte_we | input | DATA_W/8 | Left per-lane write mask |
| l_sel | input | 1 | Left select |
| l_flag_sel | input | 1 | Left side-channel select; 1 takes the port off the array |
| l_oe | input | 1 | Left output enable |
| l_busy_i | input | 1 | Left external blocked input (slave mode) |
| l_busy_o | output | 1 | Left blocked output (master mode) |
| l_rdata | output | DATA_W | Left registered read data |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | DATA_W | Right write data |
| r_byte_we | input | DATA_W/8 | Right per-lane write mask |
| r_sel | input | 1 | Right select |
| r_flag_sel | input | 1 | Right side-channel select |
| r_oe | input | 1 | Right output enable |
| r_busy_i | input | 1 | Right external blocked input (slave mode) |
| r_busy_o | output | 1 | Right blocked output (master mode) |
| r_rdata | output | DATA_W | Right registered read data |

## Verification
The assertions take the following for granted about the inputs:

- The strap is held constant while reset is high.
- In slave mode, the two ports never write the same word in the same cycle. In that mode the external blocked inputs are the only thing that orders the two ports.

The stimulus changes inputs only just after a rising edge. It changes the strap only inside a stretch of reset. Every slave-mode write goes to a word the other port is not touching.

// File: rtl/dpram_pkg.sv
// Shared types for the dual-port memory.
// Assumes: nothing beyond IEEE 1800-2017.
package dpram_pkg;
    // Which port currently holds a contested word.
    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;
endpackage

// File: rtl/dpram_port_ctl.sv
// Per-port access decode: works out whether the port is on the array,
// whether it reads this cycle, and which lanes it may write.
// Assumes: block is already resolved for master or slave mode.
module dpram_port_ctl #(
    parameter int NL = 4
) (
    input  logic          sel,
    input  logic          flag_sel,
    input  logic          oe,
    input  logic [NL-1:0] byte_we,
    input  logic          block,
    output logic          act,
    output logic          rd,
    output logic [NL-1:0] wr_lanes
);
    // Decode the port controls into array requests.
    always_comb begin
        act      = sel & ~flag_sel;
        rd       = act & oe & ~(|byte_we);
        wr_lanes = byte_we & {NL{act & ~block}};
    end
endmodule

// File: rtl/dpram_arbiter.sv
// Same-address arbiter. It compares the two active addresses and, on a
// match, grants the port that was already on that word in the previous
// cycle. Ties go to the left port. A granted port keeps the grant while
// it stays put.
// Assumes: act inputs already include select and side-channel decode.
module dpram_arbiter
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_act,
    input  logic              r_act,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [ADDR_W-1:0] r_addr,
    output logic              busy_l,
    output logic              busy_r
);
    logic              l_act_q, r_act_q;
    logic [ADDR_W-1:0] l_addr_q, r_addr_q;
    owner_e            owner_q, owner_now;
    logic              match, l_stay, r_stay;

    // Detect overlap and whether each port held its address from last cycle.
    always_comb begin
        match  = rst_n & l_act & r_act & (l_addr == r_addr);
        l_stay = l_act & l_act_q & (l_addr == l_addr_q);
        r_stay = r_act & r_act_q & (r_addr == r_addr_q);
    end

    // Choose the owner: keep a standing grant, else the earlier arrival, else left.
    always_comb begin
        owner_now = OWN_NONE;
        if (match) begin
            if (owner_q == OWN_LEFT && l_stay)       owner_now = OWN_LEFT;
            else if (owner_q == OWN_RIGHT && r_stay) owner_now = OWN_RIGHT;
            else if (r_stay && !l_stay)              owner_now = OWN_RIGHT;
            else                                     owner_now = OWN_LEFT;
        end
    end

    // Raise the blocked flag on the port that does not own the word.
    always_comb begin
        busy_l = match & (owner_now == OWN_RIGHT);
        busy_r = match & (owner_now == OWN_LEFT);
    end

    // Remember last cycle's port positions and the current owner.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l_act_q  <= 1'b0;
            r_act_q  <= 1'b0;
            l_addr_q <= '0;
            r_addr_q <= '0;
            owner_q  <= OWN_NONE;
        end else begin
            l_act_q  <= l_act;
            r_act_q  <= r_act;
            l_addr_q <= l_addr;
            r_addr_q <= r_addr;
            owner_q  <= owner_now;
        end
    end

    // R5
    grant_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy_r) && match && l_stay) |-> busy_r);
endmodule

// File: rtl/dpram_store.sv
// Two-port word storage split into byte lanes, one array per lane.
// Reads are registered and take the value held before this edge's writes.
// Assumes: the two ports never write the same lane of the same word in
// the same cycle (the arbiter or the master copy ensures it).
module dpram_store #(
    parameter int ADDR_W = 8,
    parameter int LANE_W = 8,
    parameter int NL     = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  l_addr,
    input  logic [NL*LANE_W-1:0] l_wdata,
    input  logic [NL-1:0]      l_wr_lanes,
    input  logic               l_rd,
    output logic [NL*LANE_W-1:0] l_rdata,
    input  logic [ADDR_W-1:0]  r_addr,
    input  logic [NL*LANE_W-1:0] r_wdata,
    input  logic [NL-1:0]      r_wr_lanes,
    input  logic               r_rd,
    output logic [NL*LANE_W-1:0] r_rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < NL; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] l_q, r_q;

        // Commit this lane's writes from either port.
        always_ff @(posedge clk) begin
            if (r_wr_lanes[g]) mem[r_addr] <= r_wdata[g*LANE_W +: LANE_W];
            if (l_wr_lanes[g]) mem[l_addr] <= l_wdata[g*LANE_W +: LANE_W];
        end

        // Capture read data for this lane, zero when not reading.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                l_q <= '0;
                r_q <= '0;
            end else begin
                l_q <= l_rd ? mem[l_addr] : '0;
                r_q <= r_rd ? mem[r_addr] : '0;
            end
        end

        assign l_rdata[g*LANE_W +: LANE_W] = l_q;
        assign r_rdata[g*LANE_W +: LANE_W] = r_q;
    end

    // R3
    l_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(l_rd) |-> (l_rdata == '0));
    // R3
    r_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(r_rd) |-> (r_rdata == '0));
endmodule

// File: rtl/dpram_arb.sv
// Top of the dual-port memory: two port decoders, the same-address
// arbiter and the lane storage. The strap picks who blocks writes:
// the own arbiter (master) or the external blocked inputs (slave).
// Assumes: is_master is static outside reset.
module dpram_arb #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int LANE_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       is_master,
    input  logic [ADDR_W-1:0]          l_addr,
    input  logic [DATA_W-1:0]          l_wdata,
    input  logic [DATA_W/LANE_W-1:0]   l_byte_we,
    input  logic                       l_sel,
    input  logic                       l_flag_sel,
    input  logic                       l_oe,
    input  logic                       l_busy_i,
    output logic                       l_busy_o,
    output logic [DATA_W-1:0]          l_rdata,
    input  logic [ADDR_W-1:0]          r_addr,
    input  logic [DATA_W-1:0]          r_wdata,
    input  logic [DATA_W/LANE_W-1:0]   r_byte_we,
    input  logic                       r_sel,
    input  logic                       r_flag_sel,
    input  logic                       r_oe,
    input  logic                       r_busy_i,
    output logic                       r_busy_o,
    output logic [DATA_W-1:0]          r_rdata
);
    localparam int NL = DATA_W / LANE_W;

    logic          l_act, r_act, l_rd, r_rd;
    logic [NL-1:0] l_wr, r_wr;
    logic          arb_l, arb_r, l_block, r_block;

    // Pick the write-block source from the strap; outputs only in master mode.
    always_comb begin
        l_block  = is_master ? arb_l : l_busy_i;
        r_block  = is_master ? arb_r : r_busy_i;
        l_busy_o = is_master & arb_l;
        r_busy_o = is_master & arb_r;
    end

    dpram_port_ctl #(.NL(NL)) u_lctl (
        .sel(l_sel), .flag_sel(l_flag_sel), .oe(l_oe), .byte_we(l_byte_we),
        .block(l_block), .act(l_act), .rd(l_rd), .wr_lanes(l_wr)
    );

    dpram_port_ctl #(.NL(NL)) u_rctl (
        .sel(r_sel), .flag_sel(r_flag_sel), .oe(r_oe), .byte_we(r_byte_we),
        .block(r_block), .act(r_act), .rd(r_rd), .wr_lanes(r_wr)
    );

    dpram_arbiter #(.ADDR_W(ADDR_W)) u_arb (
        .clk(clk), .rst_n(rst_n), .l_act(l_act), .r_act(r_act),
        .l_addr(l_addr), .r_addr(r_addr), .busy_l(arb_l), .busy_r(arb_r)
    );

    dpram_store #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .NL(NL)) u_store (
        .clk(clk), .rst_n(rst_n),
        .l_addr(l_addr), .l_wdata(l_wdata), .l_wr_lanes(l_wr), .l_rd(l_rd), .l_rdata(l_rdata),
        .r_addr(r_addr), .r_wdata(r_wdata), .r_wr_lanes(r_wr), .r_rd(r_rd), .r_rdata(r_rdata)
    );

    // R4
    busy_needs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (l_busy_o || r_busy_o) |-> (l_addr == r_addr && l_sel && r_sel));
    // R6
    one_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({l_busy_o, r_busy_o}));
    // R10
    slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_master |-> (!l_busy_o && !r_busy_o));
endmodule

// File: tb/tb_dpram_arb.sv
module tb_dpram_arb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam int NL = 4;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0, rst_n = 1'b0, is_master = 1'b1;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic [DW-1:0] l_wdata = '0, r_wdata = '0;
    logic [NL-1:0] l_byte_we = '0, r_byte_we = '0;
    logic l_sel = 0, l_flag_sel = 0, l_oe = 0, l_busy_i = 0;
    logic r_sel = 0, r_flag_sel = 0, r_oe = 0, r_busy_i = 0;
    logic l_busy_o, r_busy_o;
    logic [DW-1:0] l_rdata, r_rdata;
    logic [DW-1:0] ref_mem [DEPTH];
    int checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dpram_arb #(.ADDR_W(AW), .DATA_W(DW), .LANE_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .is_master(is_master),
        .l_addr(l_addr), .l_wdata(l_wdata), .l_byte_we(l_byte_we), .l_sel(l_sel),
        .l_flag_sel(l_flag_sel), .l_oe(l_oe), .l_busy_i(l_busy_i), .l_busy_o(l_busy_o),
        .l_rdata(l_rdata),
        .r_addr(r_addr), .r_wdata(r_wdata), .r_byte_we(r_byte_we), .r_sel(r_sel),
        .r_flag_sel(r_flag_sel), .r_oe(r_oe), .r_busy_i(r_busy_i), .r_busy_o(r_busy_o),
        .r_rdata(r_rdata)
    );

    function automatic logic [DW-1:0] pat(input int a, input int k);
        return (a * 32'h0100_0193 + k * 32'h2F1B_0C07) ^ 32'hA5C3_0F1E;
    endfunction

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] o, input logic [DW-1:0] n,
                                            input logic [NL-1:0] m);
        logic [DW-1:0] r = o;
        for (int i = 0; i < NL; i++) if (m[i]) r[i*8 +: 8] = n[i*8 +: 8];
        return r;
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic idle();
        l_sel = 0; l_flag_sel = 0; l_oe = 0; l_byte_we = '0;
        r_sel = 0; r_flag_sel = 0; r_oe = 0; r_byte_we = '0;
    endtask

    task automatic lset(input logic [AW-1:0] a, input logic [NL-1:0] we, input logic [DW-1:0] d, input logic oe);
        l_sel = 1; l_flag_sel = 0; l_addr = a; l_byte_we = we; l_wdata = d; l_oe = oe;
    endtask

    task automatic rset(input logic [AW-1:0] a, input logic [NL-1:0] we, input logic [DW-1:0] d, input logic oe);
        r_sel = 1; r_flag_sel = 0; r_addr = a; r_byte_we = we; r_wdata = d; r_oe = oe;
    endtask

    // Read one word through the right or left port, compare with expected.
    task automatic rd_chk(input bit left, input int a, input string req);
        idle();
        if (left) lset(a[AW-1:0], '0, '0, 1); else rset(a[AW-1:0], '0, '0, 1);
        step();
        check(req, left ? l_rdata : r_rdata, ref_mem[a]);
        idle();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R11: reset holds outputs quiet even with requests pending
        lset(8'd3, '0, '0, 1); rset(8'd3, '0, '0, 1);
        step(); step();
        check("R11 l_rdata", l_rdata, '0);
        check("R11 r_rdata", r_rdata, '0);
        check("R11 busy", {l_busy_o, r_busy_o}, '0);
        idle(); step();
        rst_n = 1; step();

        // R1/R3: full-word fill from left, read all back from right
        for (int a = 0; a < DEPTH; a++) begin
            lset(a[AW-1:0], 4'hF, pat(a, 0), 0); step();
            ref_mem[a] = pat(a, 0);
        end
        idle();
        for (int a = 0; a < DEPTH; a++) rd_chk(0, a, "R3 sweep");

        // R1: lane-masked writes from right, every mask value, read from left
        for (int a = 0; a < DEPTH; a++) begin
            rset(a[AW-1:0], a[3:0], pat(a, 1), 0); step();
            ref_mem[a] = merge(ref_mem[a], pat(a, 1), a[3:0]);
        end
        idle();
        for (int a = 0; a < DEPTH; a++) rd_chk(1, a, "R1 lanes");

        // R4: both ports write different words together, no blocking
        for (int a = 0; a < 16; a++) begin
            lset(a[AW-1:0], 4'hF, pat(a, 2), 0);
            rset(a[AW-1:0] + 8'd100, 4'hF, pat(a, 3), 0);
            #2 check("R4 busy", {l_busy_o, r_busy_o}, '0);
            step();
            ref_mem[a] = pat(a, 2); ref_mem[a + 100] = pat(a, 3);
        end
        idle();
        for (int a = 0; a < 16; a++) begin
            rd_chk(1, a, "R4 left word"); rd_chk(0, a + 100, "R4 right word");
        end

        // R2: deselected and side-channel writes do not change the array
        l_sel = 0; l_addr = 8'd7; l_byte_we = 4'hF; l_wdata = 32'hDEAD_0001; step();
        idle();
        lset(8'd7, 4'hF, 32'hDEAD_0002, 0); l_flag_sel = 1; step();
        idle();
        rd_chk(0, 7, "R2 no write");
        rset(8'd7, '0, '0, 1); r_flag_sel = 1; step();
        check("R2 side-channel read", r_rdata, '0);
        idle();
        // R3: output enable low, or a write cycle, gives zero read data
        rset(8'd7, '0, '0, 0); step();
        check("R3 oe low", r_rdata, '0);
        rset(8'd8, 4'h1, ref_mem[8], 1); step();
        check("R3 write cycle", r_rdata, '0);
        idle();

        // R5/R7/R8: right holds word 5 first, left arrives writing
        rset(8'd5, '0, '0, 1); step();
        lset(8'd5, 4'hF, 32'h1234_5678, 0);
        #2 check("R5 left blocked", {l_busy_o, r_busy_o}, 2'b10);
        step();
        check("R9 read old", r_rdata, ref_mem[5]);
        #2 check("R5 held", {l_busy_o, r_busy_o}, 2'b10);
        step();
        check("R7 inhibited", r_rdata, ref_mem[5]);
        r_sel = 0;
        #2 check("R8 release on deselect", {l_busy_o, r_busy_o}, 2'b00);
        step();
        ref_mem[5] = 32'h1234_5678;
        idle();
        rd_chk(1, 5, "R7 held write completes");

        // R6/R9: tie on word 9, both writing; left wins
        lset(8'd9, 4'hF, 32'hAAAA_1111, 0); rset(8'd9, 4'hF, 32'hBBBB_2222, 0);
        #2 check("R6 tie to left", {l_busy_o, r_busy_o}, 2'b01);
        step();
        ref_mem[9] = 32'hAAAA_1111;
        idle();
        rd_chk(0, 9, "R6 winner data");

        // R9: tie on word 20, left writes, right reads old value
        lset(8'd20, 4'hF, 32'h0F0F_F0F0, 0); rset(8'd20, '0, '0, 1);
        step();
        check("R9 old data", r_rdata, ref_mem[20]);
        ref_mem[20] = 32'h0F0F_F0F0;
        idle();
        rd_chk(1, 20, "R9 new data after");

        // R8: winner moves away, loser released in that cycle
        lset(8'd30, '0, '0, 1); rset(8'd30, '0, '0, 1); step();
        check("R6 right blocked", {l_busy_o, r_busy_o}, 2'b01);
        l_addr = 8'd31;
        #2 check("R8 release on move", {l_busy_o, r_busy_o}, 2'b00);
        step(); idle(); step();

        // R10: slave mode, blocked outputs low, external block gates writes
        rst_n = 0; is_master = 0; step(); rst_n = 1; step();
        lset(8'd41, '0, '0, 1); rset(8'd41, '0, '0, 1);
        #2 check("R10 quiet outputs", {l_busy_o, r_busy_o}, 2'b00);
        step();
        check("R10 read with block", l_rdata, ref_mem[41]);
        idle();
        l_busy_i = 1;
        lset(8'd40, 4'hF, 32'h5555_AAAA, 0); rset(8'd60, 4'hF, 32'h7777_8888, 0); step();
        ref_mem[60] = 32'h7777_8888;
        idle();
        rd_chk(1, 40, "R10 blocked write");
        rd_chk(0, 60, "R10 other port free");
        lset(8'd40, 4'hF, 32'h5555_AAAA, 0); step();
        l_busy_i = 0; step();
        ref_mem[40] = 32'h5555_AAAA;
        idle();
        rd_chk(1, 40, "R10 write after release");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule